// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a timeout supervisor that sits on a small register bus. Software programs a 16-bit limit, picks one of three tick sources and a power-of-four divider, then enables counting. Each divided tick moves an up-counter by one. When the counter is found equal to the limit on a tick, the block raises a one-cycle reset request and freezes. To keep the system alive, software writes zero to the counter register before the limit is reached.

The three tick sources are single-cycle enable strobes in the block's own clock domain: one for the peripheral clock, one for the real-time clock and one for an external clock. The block only turns these strobes into ticks. It does not make the reset itself and does not make any clock.

The bus has four word registers, selected by a 2-bit word index. Index 0 is the limit (byte offset 0x0), index 1 the run flag (0x4), index 2 the counter (0x8) and index 3 the control word (0xC). A software setup sequence is: stop, write control, write limit, clear counter, write control with the source bit, start.

Top module: `tick_watchdog`

## Requirements
- R1: After synchronous reset the limit, run flag, counter and control word are all zero, bus_rdata is zero and reset_req is low.
- R2: Writes land in the register chosen by bus_word (0 limit, 1 run flag, 2 counter, 3 control). Reads return that register on bus_rdata one cycle after bus_word is presented. The run flag keeps only bit 0. The control word keeps bits 5:0 and reads back zero above them.
- R3: Control bits 0, 1 and 2 select the tick source as src_periph, src_rtc and src_ext respectively. Strobes from sources that are not selected do not move the counter.
- R4: When the source field (control bits 2:0) has no bit set, or more than one bit set, no ticks are made and the counter does not move.
- R5: The divider code in control bits 5:3 with values 0 to 5 gives one tick for every 1, 4, 16, 64, 256 or 1024 selected strobes.
- R6: Divider codes 6 and 7 behave as a divide by 1024.
- R7: While the run flag is 0 the counter does not move. Clearing the run flag also empties the divider, so a partly accumulated count is lost.
- R8: A write to the counter register loads the written value and empties the divider. Writing zero is the service operation that restarts the timeout.
- R9: On a tick where the counter equals the limit, reset_req goes high in the following cycle for exactly one cycle. The counter then holds, and no further pulse comes until the counter is written.
- R10: A read of the counter register returns the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_periph | input | 1 | Peripheral clock tick strobe |
| src_rtc | input | 1 | Real-time clock tick strobe |
| src_ext | input | 1 | External clock tick strobe |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_word | input | 2 | Register word index (byte offset / 4) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 3-bit divider code whose largest real code is 5. With these values every divider setting can be reached within a few thousand strobes, including the divide by 1024 and the two codes above 5 that fall back to it. Small limit values bring expiry, the hold that follows it and a second expiry after service within a few cycles. The full 16-bit register width is still shown through read-back.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_RUN   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } twd_sel_e;
endpackage

// File: rtl/twd_regs.sv
module twd_regs #(
  parameter int DW    = 16,
  parameter int PSC_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [1:0]               word,
  input  logic [DW-1:0]            wdata,
  input  logic [DW-1:0]            cnt,
  output logic [DW-1:0]            limit,
  output logic                     run,
  output logic [twd_pkg::NSRC-1:0] src,
  output logic [PSC_W-1:0]         code,
  output logic                     ctrl_wr,
  output logic                     cnt_wr,
  output logic [DW-1:0]            rdata
);
  import twd_pkg::*;

  localparam int CTRL_W = NSRC + PSC_W;

  twd_sel_e          sel;
  logic [CTRL_W-1:0] ctrl_q;

  assign sel     = twd_sel_e'(word);
  assign ctrl_wr = wr && (sel == SEL_CTRL);
  assign cnt_wr  = wr && (sel == SEL_COUNT);
  assign src     = ctrl_q[NSRC-1:0];
  assign code    = ctrl_q[CTRL_W-1:NSRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      limit  <= '0;
      run    <= 1'b0;
      ctrl_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_LIMIT: limit  <= wdata;
        SEL_RUN:   run    <= wdata[0];
        SEL_CTRL:  ctrl_q <= wdata[CTRL_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_LIMIT: rdata <= limit;
        SEL_RUN:   rdata <= {{(DW-1){1'b0}}, run};
        SEL_COUNT: rdata <= cnt;
        default:   rdata <= {{(DW-CTRL_W){1'b0}}, ctrl_q};
      endcase
    end
  end
endmodule

// File: rtl/twd_tick.sv
module twd_tick #(
  parameter int PSC_W   = 3,
  parameter int PSC_MAX = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic                     clr,
  input  logic [twd_pkg::NSRC-1:0] src,
  input  logic [twd_pkg::NSRC-1:0] strb,
  input  logic [PSC_W-1:0]         code,
  output logic                     tick
);
  import twd_pkg::*;

  localparam int PRE_W = 2 * PSC_MAX;

  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  lim;
  logic [PSC_W-1:0]  eff;
  logic [NSRC-1:0]   gated;
  logic              single;
  logic              hit;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_gate
      assign gated[g] = src[g] & strb[g];
    end
  endgenerate

  always_comb begin
    single = (src != '0) && ((src & (src - 1'b1)) == '0);
    hit    = single && (gated != '0);
    eff    = (code > PSC_W'(PSC_MAX)) ? PSC_W'(PSC_MAX) : code;
    lim    = {PRE_W{1'b1}} >> (2 * (PSC_MAX - int'(eff)));
    tick   = run && hit && (pre_q == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      pre_q <= '0;
    end else if (hit) begin
      pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/twd_count.sv
module twd_count #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic [DW-1:0] limit,
  output logic [DW-1:0] cnt,
  output logic          fire
);
  logic expired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      expired_q <= 1'b0;
      fire      <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (ld) begin
        cnt       <= ld_val;
        expired_q <= 1'b0;
      end else if (tick && !expired_q) begin
        if (cnt == limit) begin
          fire      <= 1'b1;
          expired_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 3,
  parameter int PSC_MAX = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_periph,
  input  logic             src_rtc,
  input  logic             src_ext,
  input  logic             bus_wr,
  input  logic [1:0]       bus_word,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             reset_req
);
  import twd_pkg::*;

  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_val;
  logic             run_q;
  logic [NSRC-1:0]  src_q;
  logic [PSC_W-1:0] code_q;
  logic             ctrl_wr;
  logic             cnt_wr;
  logic             tick;
  logic [NSRC-1:0]  strb;

  assign strb = {src_ext, src_rtc, src_periph};

  twd_regs #(.DW(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .word(bus_word), .wdata(bus_wdata),
    .cnt(cnt_val), .limit(limit_q), .run(run_q), .src(src_q), .code(code_q),
    .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .rdata(bus_rdata)
  );

  twd_tick #(.PSC_W(PSC_W), .PSC_MAX(PSC_MAX)) u_tick (
    .clk(clk), .rst(rst), .run(run_q), .clr(ctrl_wr | cnt_wr),
    .src(src_q), .strb(strb), .code(code_q), .tick(tick)
  );

  twd_count #(.DW(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .ld(cnt_wr), .ld_val(bus_wdata),
    .limit(limit_q), .cnt(cnt_val), .fire(reset_req)
  );
endmodule

// File: rtl/twd_checker.sv
module twd_checker #(
  parameter int DW = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cnt_wr,
  input logic                     run,
  input logic [twd_pkg::NSRC-1:0] src,
  input logic [DW-1:0]            cnt,
  input logic [DW-1:0]            limit,
  input logic                     reset_req
);
  assert_single_R9: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  assert_match_R9: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> ($past(cnt) == $past(limit)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_nosrc_R4: assert property (@(posedge clk) disable iff (rst)
    (($countones(src) != 1) && !cnt_wr) |=> $stable(cnt));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));
endmodule

bind tick_watchdog twd_checker #(.DW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .run(run_q), .src(src_q),
  .cnt(cnt_val), .limit(limit_q), .reset_req(reset_req)
);

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_periph = 1'b0, src_rtc = 1'b0, src_ext = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_word = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  int req_pulses = 0;
  int req_cycles = 0;
  logic req_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_watchdog u0 (
    .clk(clk), .rst(rst), .src_periph(src_periph), .src_rtc(src_rtc),
    .src_ext(src_ext), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req)
  );

  always @(negedge clk) begin
    if (!rst && reset_req) begin
      req_cycles++;
      if (!req_prev) req_pulses++;
    end
    req_prev = reset_req;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [15:0] d);
    @(negedge clk);
    bus_word = w;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic strobe(input int which, input int n);
    if (n > 0) begin
      @(negedge clk);
      src_periph = (which == 0); src_rtc = (which == 1); src_ext = (which == 2);
      repeat (n) @(negedge clk);
      src_periph = 1'b0; src_rtc = 1'b0; src_ext = 1'b0;
    end
  endtask

  task automatic setup(input logic [15:0] lim, input logic [15:0] ctrl);
    wr(2'd1, 16'd0);
    wr(2'd3, ctrl & 16'h0038);
    wr(2'd0, lim);
    wr(2'd2, 16'd0);
    wr(2'd3, ctrl);
    wr(2'd1, 16'd1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      check("R1 register zero after reset", v, 16'd0);
    end
    check("R1 reset_req low", reset_req, 1'b0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(2'd0, 16'hBEEF); rd(2'd0, v); check("R2 limit readback", v, 16'hBEEF);
    wr(2'd3, 16'hFFFF); rd(2'd3, v); check("R2 control keeps bits 5:0", v, 16'h003F);
    wr(2'd1, 16'hFFFE); rd(2'd1, v); check("R2 run keeps bit 0 only", v, 16'd0);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R2 run set", v, 16'd1);
    wr(2'd1, 16'd0);
    wr(2'd3, 16'd0);
  endtask

  task automatic t_src();
    logic [15:0] v;
    setup(16'hFFFF, 16'h0001);
    strobe(0, 5); rd(2'd2, v); check("R3 periph source counts", v, 16'd5);
    strobe(1, 3); strobe(2, 3); rd(2'd2, v); check("R3 unselected ignored", v, 16'd5);
    wr(2'd3, 16'h0002);
    strobe(1, 4); rd(2'd2, v); check("R3 rtc source counts", v, 16'd9);
    strobe(0, 2); rd(2'd2, v); check("R3 periph ignored under rtc", v, 16'd9);
    wr(2'd3, 16'h0004);
    strobe(2, 2); rd(2'd2, v); check("R10 live count ext source", v, 16'd11);
  endtask

  task automatic t_nosrc();
    logic [15:0] v;
    setup(16'hFFFF, 16'h0000);
    strobe(0, 4); strobe(1, 4); strobe(2, 4);
    rd(2'd2, v); check("R4 no source bit", v, 16'd0);
    wr(2'd3, 16'h0003);
    strobe(0, 4); strobe(1, 4);
    rd(2'd2, v); check("R4 two source bits", v, 16'd0);
  endtask

  task automatic t_psc();
    logic [15:0] v;
    for (int c = 0; c < 8; c++) begin
      int n;
      n = (c > 5) ? 1024 : (1 << (2 * c));
      setup(16'hFFFF, 16'((c << 3) | 1));
      strobe(0, 2 * n - 1);
      rd(2'd2, v);
      check((c > 5) ? "R6 high code one short" : "R5 divider one short", v, 16'd1);
      strobe(0, 1);
      rd(2'd2, v);
      check((c > 5) ? "R6 high code full period" : "R5 divider full period", v, 16'd2);
    end
  endtask

  task automatic t_disable();
    logic [15:0] v;
    setup(16'hFFFF, 16'h0009);
    strobe(0, 3); rd(2'd2, v); check("R7 partial divider", v, 16'd0);
    wr(2'd1, 16'd0);
    strobe(0, 8); rd(2'd2, v); check("R7 stopped no count", v, 16'd0);
    wr(2'd1, 16'd1);
    strobe(0, 3); rd(2'd2, v); check("R7 divider emptied by stop", v, 16'd0);
    strobe(0, 1); rd(2'd2, v); check("R7 counts after restart", v, 16'd1);
  endtask

  task automatic t_service();
    logic [15:0] v;
    int p0;
    p0 = req_pulses;
    setup(16'd10, 16'h0001);
    strobe(0, 8); rd(2'd2, v); check("R10 live count", v, 16'd8);
    wr(2'd2, 16'd0); rd(2'd2, v); check("R8 service clears", v, 16'd0);
    strobe(0, 9); rd(2'd2, v); check("R8 count after service", v, 16'd9);
    check("R8 no expiry after service", req_pulses, p0);
    wr(2'd2, 16'h1234); rd(2'd2, v); check("R8 load written value", v, 16'h1234);
    wr(2'd2, 16'd0);
  endtask

  task automatic t_expire();
    logic [15:0] v;
    int p0, c0;
    setup(16'd3, 16'h0001);
    p0 = req_pulses; c0 = req_cycles;
    strobe(0, 3); rd(2'd2, v); check("R9 at limit", v, 16'd3);
    check("R9 no pulse before match tick", req_pulses, p0);
    @(negedge clk); src_periph = 1'b1;
    @(negedge clk); src_periph = 1'b0;
    check("R9 pulse the cycle after tick", reset_req, 1'b1);
    @(negedge clk);
    check("R9 pulse one cycle", reset_req, 1'b0);
    strobe(0, 5); rd(2'd2, v); check("R9 counter holds", v, 16'd3);
    check("R9 single pulse while held", req_pulses, p0 + 1);
    wr(2'd2, 16'd0);
    strobe(0, 4);
    @(negedge clk);
    check("R9 expires again after service", req_pulses, p0 + 2);
    check("R9 pulse width", req_cycles - c0, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_src();
    t_nosrc();
    t_psc();
    t_disable();
    t_service();
    t_expire();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule